// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block gathers message-signalled interrupts from PCIe-style requesters onto one processor interrupt line. A requester writes a small word to the doorbell register, which sits at the block's base address; that base address is the target address given to every endpoint. The write carries a vector index from 0 to 31. The block marks that vector pending in a 32-bit status register and holds its interrupt output high while any vector is pending.

Software services the line by reading the status register at byte offset 4. On every pass it scans all the set bits. The read returns the pending set and clears exactly the bits it returned. Pending bits are kept in reverse order, so vector 0 is the most significant bit of the logical status word. Both registers are big-endian on the bus: the byte lanes of the 32-bit word are swapped relative to a little-endian host.

The register port is split into two channels. The write channel carries doorbells and is always ready. The read channel takes one request at a time and returns a registered response over a valid/ready pair. A read request is accepted only when no response is waiting, or when the waiting response is taken in the same cycle. A response stays stable until the receiver takes it.

Top module: `msi_doorbell_agg`

## Requirements
- R1: A write accepted at byte offset 0 is a doorbell for one of 32 vectors. The vector index is bits [7:3] of the logical (byte-swapped) data word. Logical bits [2:0] and [31:8] are ignored.
- R2: The bus is big-endian. Logical byte k travels on bus lane 3−k, so logical bits [7:0] are on bus bits [31:24] and the vector index is on bus bits [31:27].
- R3: A doorbell for vector n sets logical status bit 31−n.
- R4: A read accepted at byte offset 4 returns the logical status word byte-swapped. Logical bit j appears on bus bit 8·(3−⌊j/8⌋)+(j mod 8).
- R5: A status read clears exactly the bits it returned. A doorbell accepted in the same cycle as that read stays pending.
- R6: `irq` is a level output that is high in every cycle in which any status bit is set.
- R7: A doorbell for a vector that is already pending is absorbed, and pending bits stay set until a status read clears them.
- R8: Writes to offset 4 or to any offset other than 0 change nothing. Reads at any offset other than 4 return zero and clear nothing.
- R9: `wr_ready` is always high. A read request is accepted when `rd_valid` and `rd_ready` are both high. Its response appears on `rsp_valid`/`rsp_data` in the next cycle and is held stable until `rsp_ready` is high. While a response is held, `rd_ready` is low.
- R10: A synchronous active-high `rst` clears all pending bits, deasserts `irq` and drops any response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready (always high) |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data, big-endian lanes |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | 8 | Read byte offset |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 32 | Read response data, big-endian lanes |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench targets the following corner cases, with the failure each one catches:
- Index extremes 0 and 31, and data words with the ignored bits set. A design that picked the wrong lane or field would light the wrong status bit, or none.
- A doorbell accepted in the same edge as a status read. A design that cleared its whole register would drop that doorbell.
- A stalled response while further doorbells arrive. A design that let the held data change, or accepted a second read, would return the wrong set or lose the bits it cleared.
- Writes to the status offset, reads of the doorbell offset, and reset in the middle of pending activity. In these cases a wrong design would change or clear pending state it should leave alone.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned VEC_COUNT   = 32;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned OFFS_W      = 8;
  localparam int unsigned INDEX_SHIFT = 3;
  localparam int unsigned INDEX_W     = $clog2(VEC_COUNT);
  localparam logic [OFFS_W-1:0] OFFS_DOORBELL = 8'h00;
  localparam logic [OFFS_W-1:0] OFFS_STATUS   = 8'h04;
endpackage

// File: rtl/msi_lane_swap.sv
module msi_lane_swap #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] in_word,
  output logic [WIDTH-1:0] out_word
);
  localparam int unsigned LANES = WIDTH / 8;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign out_word[8*b +: 8] = in_word[8*(LANES-1-b) +: 8];
  end
endmodule

// File: rtl/msi_vec_decode.sv
module msi_vec_decode
  import msi_agg_pkg::*;
#(
  parameter int unsigned NVEC  = VEC_COUNT,
  parameter int unsigned WIDTH = WORD_W,
  parameter int unsigned SHIFT = INDEX_SHIFT
) (
  input  logic             strobe,
  input  logic [WIDTH-1:0] logical_word,
  output logic [NVEC-1:0]  set_mask
);
  localparam int unsigned IDX_W = $clog2(NVEC);
  localparam logic [WIDTH-1:0] USED_BITS = WIDTH'(((1 << IDX_W) - 1) << SHIFT);

  logic [IDX_W-1:0] vec_idx;
  logic             unused_bits;

  assign vec_idx     = logical_word[SHIFT +: IDX_W];
  assign unused_bits = ^(logical_word & ~USED_BITS);

  // Reverse placement: vector n lands on bit NVEC-1-n (R3)
  for (genvar i = 0; i < NVEC; i++) begin : g_bit
    assign set_mask[i] = strobe && (vec_idx == IDX_W'(NVEC - 1 - i));
  end

  // R1: at most one vector per doorbell
  always_comb begin
    a_r1_single_vector: assert ($onehot0(set_mask));
  end
endmodule

// File: rtl/msi_pending_reg.sv
module msi_pending_reg #(
  parameter int unsigned NVEC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NVEC-1:0] set_mask,
  input  logic            take_all,
  output logic [NVEC-1:0] pend,
  output logic            any_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else if (take_all) begin
      pend <= set_mask;
    end else begin
      pend <= pend | set_mask;
    end
  end

  assign any_pend = |pend;

  a_r3_set_lands: assert property (@(posedge clk) disable iff (rst)
    (|set_mask) |=> ((pend & $past(set_mask)) == $past(set_mask)));

  a_r5_clear_returned: assert property (@(posedge clk) disable iff (rst)
    (take_all && set_mask == '0) |=> (pend == '0));

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    !take_all |=> ((pend & $past(pend)) == $past(pend)));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (pend == '0 && !any_pend));
endmodule

// File: rtl/msi_doorbell_agg.sv
module msi_doorbell_agg
  import msi_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [OFFS_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [OFFS_W-1:0] rd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              irq
);
  logic                 wr_fire, db_hit, rd_fire, st_read;
  logic [WORD_W-1:0]    wr_logical, status_bus;
  logic [VEC_COUNT-1:0] set_mask, pend;
  logic                 any_pend;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign db_hit   = wr_fire && (wr_addr == OFFS_DOORBELL);

  assign rd_ready = !rsp_valid || rsp_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign st_read  = rd_fire && (rd_addr == OFFS_STATUS);

  msi_lane_swap #(.WIDTH(WORD_W)) u_wr_swap (
    .in_word (wr_data),
    .out_word(wr_logical)
  );

  msi_vec_decode #(.NVEC(VEC_COUNT), .WIDTH(WORD_W), .SHIFT(INDEX_SHIFT)) u_decode (
    .strobe      (db_hit),
    .logical_word(wr_logical),
    .set_mask    (set_mask)
  );

  msi_pending_reg #(.NVEC(VEC_COUNT)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_mask(set_mask),
    .take_all(st_read),
    .pend    (pend),
    .any_pend(any_pend)
  );

  msi_lane_swap #(.WIDTH(WORD_W)) u_rd_swap (
    .in_word (pend),
    .out_word(status_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= st_read ? status_bus : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign irq = any_pend;

  a_r6_irq_needs_doorbell: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(db_hit));

  a_r9_rsp_held: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r9_rsp_follows_accept: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> rsp_valid);
endmodule

// File: tb/test_msi_doorbell_agg.sv
`timescale 1ns/1ps
module test_msi_doorbell_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0, rd_valid = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, rd_ready, rsp_valid, irq;
  logic [31:0] rsp_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  msi_doorbell_agg i_msi_doorbell_agg (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .irq(irq)
  );

  // logical doorbell data words and the logical status each should produce
  localparam logic [31:0] TV_DATA [0:5] = '{32'h0000_0000, 32'h0000_00F8, 32'h0000_0047,
                                             32'hFFFF_FF0F, 32'h0000_0088, 32'h0000_0038};
  localparam logic [31:0] TV_EXP  [0:5] = '{32'h8000_0000, 32'h0000_0001, 32'h0080_0000,
                                             32'h4000_0000, 32'h0000_4000, 32'h0100_0000};

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] vec_data(input int n);
    return bswap(32'(n) << 3);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R9 response valid after accept", {31'd0, rsp_valid}, 32'd1);
    d = rsp_data;
  endtask

  logic [31:0] got;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq low after reset", {31'd0, irq}, 32'd0);
    chk("R9 wr_ready high", {31'd0, wr_ready}, 32'd1);
    do_read(8'h04, got);
    chk("R10 status zero after reset", got, 32'd0);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      do_write(8'h00, bswap(TV_DATA[i]));
      chk($sformatf("R6 irq after doorbell %0d", i), {31'd0, irq}, 32'd1);
      do_read(8'h04, got);
      chk($sformatf("R1 R2 R3 R4 status vector %0d", i), got, bswap(TV_EXP[i]));
      chk($sformatf("R6 irq low after read %0d", i), {31'd0, irq}, 32'd0);
      do_read(8'h04, got);
      chk($sformatf("R5 cleared after read %0d", i), got, 32'd0);
    end

    // R7 repeated doorbells and multiple vectors
    do_write(8'h00, vec_data(9));
    do_write(8'h00, vec_data(9));
    do_write(8'h00, vec_data(30));
    do_read(8'h04, got);
    chk("R7 repeat absorbed, both pending", got, bswap(32'h0040_0002));

    // R8 ignored writes and zero reads
    do_write(8'h04, 32'hFFFF_FFFF);
    do_write(8'h0C, vec_data(3));
    chk("R8 irq after ignored writes", {31'd0, irq}, 32'd0);
    do_read(8'h04, got);
    chk("R8 ignored writes leave status", got, 32'd0);
    do_write(8'h00, vec_data(12));
    do_read(8'h00, got);
    chk("R8 doorbell offset reads zero", got, 32'd0);
    do_read(8'h08, got);
    chk("R8 other offset reads zero", got, 32'd0);
    chk("R8 irq kept after other reads", {31'd0, irq}, 32'd1);
    do_read(8'h04, got);
    chk("R8 status intact after other reads", got, bswap(32'h0008_0000));

    // R5 same-cycle doorbell and status read
    do_write(8'h00, vec_data(2));
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 8'h00; wr_data = vec_data(5);
    rd_valid = 1'b1; rd_addr = 8'h04;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    chk("R5 read returns prior set", rsp_data, bswap(32'h2000_0000));
    chk("R5 concurrent doorbell keeps irq", {31'd0, irq}, 32'd1);
    do_read(8'h04, got);
    chk("R5 concurrent doorbell stays pending", got, bswap(32'h0400_0000));

    // R9 back-pressure
    do_write(8'h00, vec_data(3));
    @(negedge clk);
    rsp_ready = 1'b0; rd_valid = 1'b1; rd_addr = 8'h04;
    @(negedge clk);
    chk("R9 rd_ready low while held", {31'd0, rd_ready}, 32'd0);
    got = rsp_data;
    chk("R9 held response data", got, bswap(32'h1000_0000));
    wr_valid = 1'b1; wr_addr = 8'h00; wr_data = vec_data(4);
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
    chk("R9 held data stable", rsp_data, got);
    chk("R9 valid stays while stalled", {31'd0, rsp_valid}, 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R9 second read after release", rsp_data, bswap(32'h0800_0000));
    do_read(8'h04, got);
    chk("R9 nothing left pending", got, 32'd0);

    // R10 reset mid-activity
    do_write(8'h00, vec_data(0));
    do_write(8'h00, vec_data(31));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 irq low after mid reset", {31'd0, irq}, 32'd0);
    do_read(8'h04, got);
    chk("R10 status cleared by reset", got, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule